// File: doc/BRIEF.md
# Clock-Activity Power and Soft-Mute Controller

This block decides the power state of a stereo audio output path by watching the incoming master clock, bit clock and frame clock. It samples them with a free-running reference clock and combines what it sees with an active-low mute input. There are no configuration registers. The path is Off while the master clock is absent. It sits in Standby while the master clock runs but the bit clock is gone or mute is held. It is Enabled when both clocks run and mute is released.

Each frame, one left and one right sample pass through a shared gain code. The code stays at full scale while Enabled. When the path leaves Enabled because mute is asserted or the bit clock stops, the code falls by one step on every frame and the path stays on until the code reaches zero. Only then is Standby reported. Releasing mute with the bit clock running restores full scale at once.

The states are Off, Standby, Enabled and an internal Drain state, which is reported as Enabled. The transitions are:
- power-up from Off to Enabled or to Standby;
- Standby to Enabled on wake;
- Enabled into Drain on mute or bit-clock loss;
- Drain to Standby when the code reaches zero;
- Drain back to Enabled on un-mute;
- any state to Off on master-clock loss.

Top module: `clkact_pwr_mute`

## Requirements
- R1: After reset, pwr_state_o reads 0 (Off), gain_o reads 0 and both sample outputs read 0. The pwr_state_o encoding is 0 = Off, 1 = Standby, 2 = Enabled.
- R2: A monitored clock counts as stopped once CLK_DEAD_CYC reference cycles pass with no edge of it (FRAME_DEAD_CYC for the frame clock). It counts as running again after LIVE_EDGES edges, each arriving less than that window after the one before.
- R3: From Off, once master and bit clock both run, the state becomes Enabled if mute_n_i is 1 and Standby if mute_n_i is 0. With only the master clock running it stays Off.
- R4: In Standby with the master clock running, a stopped bit clock keeps the state at Standby.
- R5: From Standby, mute_n_i = 1 together with a running bit clock moves the state to Enabled with gain_o at full scale.
- R6: From Enabled, mute_n_i = 0 or a stopped bit clock starts the ramp. pwr_state_o keeps reading Enabled and the outputs stay active until gain_o reaches 0, and the state then reads Standby. Enabled never goes straight to Standby.
- R7: A stopped master clock sends the state to Off from any state, with gain_o and both outputs at 0.
- R8: Full scale is the code RAMP_LEN. During the ramp, gain_o falls by exactly 1 at each rising frame-clock edge and reaches 0 after RAMP_LEN frames. It never exceeds RAMP_LEN.
- R9: Releasing mute during the ramp while the bit clock runs restores gain_o to RAMP_LEN in one step.
- R10: At each rising frame-clock edge while the path is active, each output captures its input (two's complement) times the gain code in use before that edge's step, divided by RAMP_LEN and truncated toward zero. Both channels use the same code. While the path is inactive, both outputs are 0.
- R11: If the frame clock stops during the ramp, gain_o drops to 0 and the state goes to Standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock to be monitored |
| bclk_i | input | 1 | Bit clock to be monitored |
| lrclk_i | input | 1 | Frame clock; rising edge marks a new sample pair |
| mute_n_i | input | 1 | Active-low mute request |
| left_i | input | DATA_W | Left sample, two's complement |
| right_i | input | DATA_W | Right sample, two's complement |
| left_o | output | DATA_W | Scaled left sample |
| right_o | output | DATA_W | Scaled right sample |
| pwr_state_o | output | 2 | Reported power state (0 Off, 1 Standby, 2 Enabled) |
| gain_o | output | GAIN_W | Current gain code |
| path_en_o | output | 1 | Output path active |

## Verification
The bench builds the block with 8-bit samples, a 4-bit gain code and a ramp of 8 frames. Dead windows are 40 reference cycles and LIVE_EDGES is 4, so every state and transition is reached within a few hundred cycles. With 8-bit samples, all 256 input values can be swept at unity gain. With an 8-frame ramp, each gain step is checked with arithmetic expectations on both channels across several ramps.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_STBY  = 2'd1,
        PS_ON    = 2'd2,
        PS_DRAIN = 2'd3
    } pwr_state_e;

    localparam logic [1:0] RPT_OFF  = 2'd0;
    localparam logic [1:0] RPT_STBY = 2'd1;
    localparam logic [1:0] RPT_ON   = 2'd2;

    function automatic logic [1:0] report_code(pwr_state_e s);
        logic [1:0] r;
        unique case (s)
            PS_OFF:   r = RPT_OFF;
            PS_STBY:  r = RPT_STBY;
            PS_ON:    r = RPT_ON;
            PS_DRAIN: r = RPT_ON;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpm_act_mon.sv
module cpm_act_mon #(
    parameter int DEAD_CYC   = 64,
    parameter int LIVE_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_i,
    output logic live_o,
    output logic rise_o
);
    localparam int IW = $clog2(DEAD_CYC + 1);
    localparam int EW = $clog2(LIVE_EDGES + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(DEAD_CYC - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(LIVE_EDGES - 1);

    logic [2:0]    sync_q;
    logic [IW-1:0] idle_q;
    logic [EW-1:0] ecnt_q;
    logic          live_q;
    logic          edge_seen;

    assign edge_seen = sync_q[1] ^ sync_q[2];
    assign rise_o    = sync_q[1] & ~sync_q[2];
    assign live_o    = live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], mon_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            ecnt_q <= '0;
            live_q <= 1'b0;
        end else if (edge_seen) begin
            idle_q <= '0;
            if (!live_q) begin
                if (ecnt_q == EDGE_LAST) begin
                    live_q <= 1'b1;
                    ecnt_q <= '0;
                end else begin
                    ecnt_q <= ecnt_q + 1'b1;
                end
            end
        end else if (idle_q == IDLE_LAST) begin
            live_q <= 1'b0;
            ecnt_q <= '0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R2
    live_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live_q) |-> $past(edge_seen));

    // R2
    live_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(live_q) |-> ($past(idle_q) == IDLE_LAST && !$past(edge_seen)));

endmodule

// File: rtl/cpm_pwr_fsm.sv
module cpm_pwr_fsm
    import cpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_live_i,
    input  logic       bclk_live_i,
    input  logic       frame_live_i,
    input  logic       mute_n_i,
    input  logic       gain_zero_i,
    output logic [1:0] state_o,
    output logic       path_en_o,
    output logic       load_full_o,
    output logic       drain_o,
    output logic       flush_o
);
    pwr_state_e cur_q, nxt;
    logic       wake;

    assign wake = mute_n_i && bclk_live_i;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            PS_OFF: begin
                if (mclk_live_i && bclk_live_i)
                    nxt = mute_n_i ? PS_ON : PS_STBY;
            end
            PS_STBY: begin
                if (!mclk_live_i)  nxt = PS_OFF;
                else if (wake)     nxt = PS_ON;
            end
            PS_ON: begin
                if (!mclk_live_i)  nxt = PS_OFF;
                else if (!wake)    nxt = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (!mclk_live_i)      nxt = PS_OFF;
                else if (wake)         nxt = PS_ON;
                else if (gain_zero_i)  nxt = PS_STBY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= PS_OFF;
        else        cur_q <= nxt;
    end

    always_comb begin
        state_o     = report_code(cur_q);
        path_en_o   = 1'b0;
        load_full_o = 1'b0;
        drain_o     = 1'b0;
        flush_o     = 1'b0;
        unique case (cur_q)
            PS_OFF:   flush_o = 1'b1;
            PS_STBY:  flush_o = 1'b1;
            PS_ON: begin
                path_en_o   = 1'b1;
                load_full_o = 1'b1;
            end
            PS_DRAIN: begin
                path_en_o = 1'b1;
                drain_o   = 1'b1;
                flush_o   = !frame_live_i;
            end
        endcase
    end

    // R7
    mclk_loss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_live_i |=> (state_o == RPT_OFF));

    // R4
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == PS_STBY && mclk_live_i && !bclk_live_i) |=> (state_o == RPT_STBY));

    // R6
    no_direct_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == PS_ON) |=> (cur_q != PS_STBY));

    // R6
    drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == PS_DRAIN && gain_zero_i && mclk_live_i && !wake) |=> (state_o == RPT_STBY));

endmodule

// File: rtl/cpm_gain_ramp.sv
module cpm_gain_ramp #(
    parameter int GAIN_W   = 10,
    parameter int RAMP_LEN = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              load_full_i,
    input  logic              drain_i,
    input  logic              tick_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              zero_o
);
    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_LEN);

    logic [GAIN_W-1:0] gain_q;

    assign gain_o = gain_q;
    assign zero_o = (gain_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= '0;
        end else if (flush_i) begin
            gain_q <= '0;
        end else if (load_full_i) begin
            gain_q <= FULL;
        end else if (drain_i && tick_i && !zero_o) begin
            gain_q <= gain_q - 1'b1;
        end
    end

    // R8
    gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= FULL);

    // R8
    gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && !flush_i) |=>
            (gain_q == $past(gain_q) || gain_q == $past(gain_q) - GAIN_W'(1)));

endmodule

// File: rtl/cpm_scale.sv
module cpm_scale #(
    parameter int DATA_W   = 24,
    parameter int GAIN_W   = 10,
    parameter int RAMP_LEN = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [DATA_W-1:0] samp_i,
    output logic [DATA_W-1:0] samp_o
);
    localparam int PW = DATA_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] DIVISOR = PW'(RAMP_LEN);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;
    logic [DATA_W-1:0]    out_q;

    assign prod   = PW'($signed(samp_i)) * $signed({1'b0, gain_i});
    assign quot   = prod / DIVISOR;
    assign samp_o = out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (!en_i) begin
            out_q <= '0;
        end else if (tick_i) begin
            out_q <= quot[DATA_W-1:0];
        end
    end

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (out_q == '0));

endmodule

// File: rtl/clkact_pwr_mute.sv
module clkact_pwr_mute #(
    parameter int DATA_W         = 24,
    parameter int GAIN_W         = 10,
    parameter int RAMP_LEN       = 800,
    parameter int CLK_DEAD_CYC   = 64,
    parameter int FRAME_DEAD_CYC = 4096,
    parameter int LIVE_EDGES     = 4
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              mclk_i,
    input  logic              bclk_i,
    input  logic              lrclk_i,
    input  logic              mute_n_i,
    input  logic [DATA_W-1:0] left_i,
    input  logic [DATA_W-1:0] right_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic [1:0]        pwr_state_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic              path_en_o
);
    localparam int NMON  = 3;
    localparam int NCH   = 2;
    localparam int M_IDX = 0;
    localparam int B_IDX = 1;
    localparam int F_IDX = 2;

    logic [NMON-1:0]   mon_in;
    logic [NMON-1:0]   mon_live;
    logic [NMON-1:0]   mon_rise;
    logic [1:0]        mute_sync_q;
    logic              path_en, load_full, drain, flush, gain_zero;
    logic [GAIN_W-1:0] gain;
    logic [DATA_W-1:0] ch_in  [NCH];
    logic [DATA_W-1:0] ch_out [NCH];

    assign mon_in = {lrclk_i, bclk_i, mclk_i};

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) mute_sync_q <= '0;
        else        mute_sync_q <= {mute_sync_q[0], mute_n_i};
    end

    for (genvar g = 0; g < NMON; g++) begin : g_mon
        cpm_act_mon #(
            .DEAD_CYC  ((g == F_IDX) ? FRAME_DEAD_CYC : CLK_DEAD_CYC),
            .LIVE_EDGES(LIVE_EDGES)
        ) mon_i (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .mon_i (mon_in[g]),
            .live_o(mon_live[g]),
            .rise_o(mon_rise[g])
        );
    end

    cpm_pwr_fsm fsm_i (
        .clk         (ref_clk),
        .rst_n       (rst_n),
        .mclk_live_i (mon_live[M_IDX]),
        .bclk_live_i (mon_live[B_IDX]),
        .frame_live_i(mon_live[F_IDX]),
        .mute_n_i    (mute_sync_q[1]),
        .gain_zero_i (gain_zero),
        .state_o     (pwr_state_o),
        .path_en_o   (path_en),
        .load_full_o (load_full),
        .drain_o     (drain),
        .flush_o     (flush)
    );

    cpm_gain_ramp #(
        .GAIN_W  (GAIN_W),
        .RAMP_LEN(RAMP_LEN)
    ) ramp_i (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .load_full_i(load_full),
        .drain_i    (drain),
        .tick_i     (mon_rise[F_IDX]),
        .gain_o     (gain),
        .zero_o     (gain_zero)
    );

    assign ch_in[0] = left_i;
    assign ch_in[1] = right_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cpm_scale #(
            .DATA_W  (DATA_W),
            .GAIN_W  (GAIN_W),
            .RAMP_LEN(RAMP_LEN)
        ) scale_i (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .en_i  (path_en),
            .tick_i(mon_rise[F_IDX]),
            .gain_i(gain),
            .samp_i(ch_in[c]),
            .samp_o(ch_out[c])
        );
    end

    assign left_o    = ch_out[0];
    assign right_o   = ch_out[1];
    assign gain_o    = gain;
    assign path_en_o = path_en;

    // R11
    frame_loss_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (drain && !mon_live[F_IDX]) |=> (gain_o == '0));

    // R6
    active_report_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        path_en_o |-> (pwr_state_o == 2'd2));

endmodule

// File: tb/clkact_pwr_mute_tb_top.sv
`timescale 1ns/1ps
module clkact_pwr_mute_tb_top;
    localparam int DW = 8;
    localparam int GW = 4;
    localparam int RL = 8;
    localparam int DEAD = 40;
    localparam int LIVE = 4;
    localparam int CLK_HALF = 2;
    localparam int LR_HALF = 12;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0, bclk = 1'b0, lrclk = 1'b0;
    logic mute_n = 1'b0;
    logic [DW-1:0] left_in = '0, right_in = '0;
    logic [DW-1:0] left_out, right_out;
    logic [1:0] st;
    logic [GW-1:0] gain;
    logic path_en;

    bit m_run = 0, b_run = 0, l_run = 0;
    int mc = 0, bc = 0, lc = 0;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2 ref_clk = ~ref_clk;

    clkact_pwr_mute #(
        .DATA_W(DW), .GAIN_W(GW), .RAMP_LEN(RL),
        .CLK_DEAD_CYC(DEAD), .FRAME_DEAD_CYC(DEAD), .LIVE_EDGES(LIVE)
    ) dut_i (
        .ref_clk(ref_clk), .rst_n(rst_n),
        .mclk_i(mclk), .bclk_i(bclk), .lrclk_i(lrclk), .mute_n_i(mute_n),
        .left_i(left_in), .right_i(right_in),
        .left_o(left_out), .right_o(right_out),
        .pwr_state_o(st), .gain_o(gain), .path_en_o(path_en)
    );

    always @(negedge ref_clk) begin
        if (m_run) begin mc++; if (mc >= CLK_HALF) begin mc = 0; mclk <= ~mclk; end end
        if (b_run) begin bc++; if (bc >= CLK_HALF) begin bc = 0; bclk <= ~bclk; end end
        if (l_run) begin lc++; if (lc >= LR_HALF) begin lc = 0; lrclk <= ~lrclk; end end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wait_frame();
        @(posedge lrclk);
        cyc(6);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        int g;
        int s;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 state", st, 0);
        chk("R1 gain", gain, 0);
        chk("R1 left", left_out, 0);

        // R3 master clock alone keeps Off
        mute_n = 1'b1;
        m_run = 1;
        cyc(100);
        chk("R3 mclk only", st, 0);
        b_run = 1;
        l_run = 1;
        cyc(60);
        chk("R3 off to enabled", st, 2);
        chk("R8 full scale", gain, RL);

        // R10 unity sweep over every sample value
        for (int v = -128; v < 128; v++) begin
            left_in = DW'(v);
            right_in = DW'(-1 - v);
            wait_frame();
            chk("R10 unity left", $signed(left_out), v);
            chk("R10 unity right", $signed(right_out), -1 - v);
        end

        // R6 R8 R10 mute ramps
        for (int rep = 0; rep < 3; rep++) begin
            wait_frame();
            mute_n = 1'b0;
            g = RL;
            for (int k = 0; k < RL; k++) begin
                s = ((rep * 53 + k * 29 + 7) % 256) - 128;
                left_in = DW'(s);
                right_in = DW'(-s / 2);
                wait_frame();
                chk("R8 ramp step", gain, g - 1);
                if (g > 1) begin
                    chk("R10 ramp left", $signed(left_out), (s * g) / RL);
                    chk("R10 ramp right", $signed(right_out), ((-s / 2) * g) / RL);
                    chk("R6 still enabled", st, 2);
                end else begin
                    chk("R6 standby after ramp", st, 1);
                    chk("R6 output cleared", left_out, 0);
                end
                g--;
            end
            mute_n = 1'b1;
            wait_frame();
            wait_frame();
            chk("R5 wake state", st, 2);
            chk("R5 wake gain", gain, RL);
        end

        // R9 unmute mid ramp
        wait_frame();
        mute_n = 1'b0;
        for (int i = 1; i <= 3; i++) begin
            wait_frame();
            chk("R9 partial ramp", gain, RL - i);
        end
        mute_n = 1'b1;
        cyc(10);
        chk("R9 gain restored", gain, RL);
        chk("R9 state", st, 2);
        left_in = DW'(77);
        wait_frame();
        chk("R9 full output", $signed(left_out), 77);

        // R2 R6 bit clock loss
        b_run = 0;
        cyc(DEAD - 10);
        chk("R2 not yet dead", gain, RL);
        cyc(30);
        chk("R6 draining reports enabled", st, 2);
        repeat (RL + 3) wait_frame();
        chk("R6 bclk loss standby", st, 1);
        chk("R6 bclk loss gain", gain, 0);
        // R4 stays in Standby
        cyc(200);
        chk("R4 hold standby", st, 1);
        b_run = 1;
        cyc(3);
        chk("R2 not yet live", st, 1);
        cyc(30);
        chk("R5 bclk back", st, 2);
        chk("R5 gain", gain, RL);

        // R11 frame clock loss during ramp
        b_run = 0;
        l_run = 0;
        cyc(2 * DEAD + 20);
        chk("R11 state", st, 1);
        chk("R11 gain", gain, 0);
        chk("R11 left", left_out, 0);
        b_run = 1;
        l_run = 1;
        cyc(40);
        chk("R5 resume", st, 2);

        // R7 master clock loss
        m_run = 0;
        cyc(DEAD + 10);
        chk("R7 off state", st, 0);
        chk("R7 gain", gain, 0);
        chk("R7 right", right_out, 0);
        mute_n = 1'b0;
        m_run = 1;
        cyc(30);
        chk("R3 off to standby", st, 1);
        m_run = 0;
        cyc(DEAD + 10);
        chk("R7 standby to off", st, 0);
        mute_n = 1'b1;
        m_run = 1;
        cyc(30);
        chk("R3 off to enabled again", st, 2);

        finish_run();
    end
endmodule